// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two up-counting channels. Each channel keeps a low count byte and a high count byte. A machine-cycle strobe, produced by dividing the system clock by twelve, is shared by both channels. Each channel advances either on that strobe or on falling edges of its own event pin. The event pin is synchronized and then sampled once per machine cycle. A gate option lets an external level pin hold a channel stopped even when its run bit is set.

Software sees six byte registers: a mode register, a control register holding the run bits and overflow flags, and the four count bytes. Writes are synchronous. Reads are combinational from a separate read address.

Each channel can be a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads itself from the high byte. A fourth mode splits channel 0 into two free 8-bit counters and freezes channel 1. Each overflow flag drives an interrupt request line directly. An acknowledge input clears that flag.

Top module: `dual_timer`

## Requirements
- R1: In timer mode an enabled channel advances by exactly one count per machine cycle, and a machine cycle is 12 clocks. Any 12·k consecutive clocks after enabling advance the count by exactly k.
- R2: In counter mode an enabled channel advances once for each high-to-low change of its event pin. Each pin level must last more than one machine cycle. The machine-cycle strobe does not advance the channel in this mode.
- R3: Mode nibble bit 3 is the gate. With gate 0 the channel runs whenever its run bit is 1. With gate 1 it also needs its gate pin high, and it holds its count while the pin is low.
- R4: Mode 00 (nibble bits 1:0) counts 13 bits. Bits 4:0 of the low byte carry into the high byte, and a carry out of the high byte sets the flag. Low-byte bits 7:5 keep whatever was last written.
- R5: Mode 01 counts 16 bits as {high, low}. The step from FFFFh to 0000h sets the flag.
- R6: Mode 10 counts in the low byte. A step from FFh loads the low byte from the high byte and sets the flag. The high byte is left unchanged.
- R7: Mode 11 on channel 0 makes the low byte an 8-bit counter that sets flag 0 when it wraps. The high byte becomes a second 8-bit counter that counts machine cycles while run bit 1 is set, and its wrap sets flag 1.
- R8: Mode 11 on channel 1 holds both of its count bytes, even with run bit 1 set.
- R9: Register addresses are 0 mode, 1 control, 2/3 channel 0 low/high, 4/5 channel 1 low/high. Mode bits 7:4 belong to channel 1 and bits 3:0 to channel 0. Each nibble is ordered gate, count-select (1 = event pin), mode bit 1, mode bit 0. Control bit 7 is flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0, and bits 3:0 read as zero.
- R10: Each irq output equals its flag. A hardware set beats an acknowledge or a control-register write in the same cycle. An acknowledge clears the flag. A control write loads the flag bits.
- R11: A write to either count byte of a channel replaces that channel's whole step in that cycle. Counting resumes from the written value.
- R12: After reset all registers read zero and both irq outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ev_pin | input | 2 | Event input per channel (asynchronous) |
| gate_pin | input | 2 | Gate level per channel (synchronous) |
| irq_ack | input | 2 | Interrupt acknowledge per channel |
| irq | output | 2 | Interrupt request per channel |

## Verification
A timer step lands on the clock edge where the shared strobe is high. The bench therefore never assumes the strobe's phase. It opens each run window on the edge that writes the run bit, and it reads the count exactly 12·k clocks later, where k steps are due whatever the phase. Event-pin counts are due within two synchronizer clocks plus one machine cycle after each falling edge, so the bench reads them after a settling gap longer than that. The set-beats-acknowledge and write-beats-step checks need one exact edge. For these the bench first polls until it sees a step, then drives its stimulus on the edge 12 clocks later. Flags and irq change on the same edge as the overflowing step and are read at the next falling clock edge.

// File: rtl/dtmr_pkg.sv
// Shared types and register addresses for the dual timer.
// Assumes a 3-bit register address space with byte-wide registers.
package dtmr_pkg;
    typedef enum logic [1:0] {
        MD_13    = 2'b00,
        MD_16    = 2'b01,
        MD_RLD   = 2'b10,
        MD_SPLIT = 2'b11
    } cnt_mode_e;

    // One channel's nibble of the mode register, MSB first.
    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        cnt_mode_e mode;
    } chan_cfg_t;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;
endpackage

// File: rtl/mc_prescaler.sv
// Machine-cycle strobe: tick is high for one clock out of every DIV.
// Assumes DIV >= 2. The count restarts at zero on reset.
module mc_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ev_detect.sv
// Event-pin front end: a two-flop synchronizer, then one sample per
// machine cycle. fall is high on a tick whose sample is low while the
// previous sample was high. Assumes each pin level lasts longer than a
// machine cycle.
module ev_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic [1:0] sync_q;
    logic       samp_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], pin};
    end

    // Hold the previous machine-cycle sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    samp_q <= 1'b0;
        else if (tick) samp_q <= sync_q[1];
    end

    assign fall = tick && samp_q && !sync_q[1];

    // R2
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> tick);
endmodule

// File: rtl/tc_channel.sv
// One timer/counter channel: low and high count bytes with the four
// counting structures. step advances the main counter. aux_step advances
// the high byte in split mode, and only when SPLIT_OK is 1. A write to
// either byte replaces the whole step of that cycle. Assumes step and
// aux_step are single-clock pulses.
module tc_channel
    import dtmr_pkg::*;
#(
    parameter int W        = 8,
    parameter int LO13_W   = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_mode_e    mode,
    input  logic         step,
    input  logic         aux_step,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         ovf_main,
    output logic         ovf_aux
);
    logic [W-1:0]   lo_q, hi_q, lo_d, hi_d;
    logic [2*W-1:0] wide_inc;
    logic           wr_any;

    assign wr_any   = wr_lo || wr_hi;
    assign wide_inc = {hi_q, lo_q} + 1'b1;

    // Next-state and overflow decode for the selected structure.
    always_comb begin
        lo_d     = lo_q;
        hi_d     = hi_q;
        ovf_main = 1'b0;
        ovf_aux  = 1'b0;
        if (wr_any) begin
            if (wr_lo) lo_d = wdata;
            if (wr_hi) hi_d = wdata;
        end else begin
            case (mode)
                MD_13: if (step) begin
                    lo_d[LO13_W-1:0] = lo_q[LO13_W-1:0] + 1'b1;
                    if (&lo_q[LO13_W-1:0]) begin
                        hi_d     = hi_q + 1'b1;
                        ovf_main = &hi_q;
                    end
                end
                MD_16: if (step) begin
                    {hi_d, lo_d} = wide_inc;
                    ovf_main     = &{hi_q, lo_q};
                end
                MD_RLD: if (step) begin
                    if (&lo_q) begin
                        lo_d     = hi_q;
                        ovf_main = 1'b1;
                    end else begin
                        lo_d = lo_q + 1'b1;
                    end
                end
                MD_SPLIT: if (SPLIT_OK) begin
                    if (step) begin
                        lo_d     = lo_q + 1'b1;
                        ovf_main = &lo_q;
                    end
                    if (aux_step) begin
                        hi_d    = hi_q + 1'b1;
                        ovf_aux = &hi_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign lo = lo_q;
    assign hi = hi_q;

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !aux_step && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RLD && step && (&lo_q) && !wr_any) |=>
            (lo_q == $past(hi_q) && $stable(hi_q)));

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_q == $past(wdata)));

    generate
        if (!SPLIT_OK) begin : g_freeze
            // R8
            freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == MD_SPLIT && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));
        end
    endgenerate
endmodule

// File: rtl/dual_timer.sv
// Dual four-mode timer/counter top. It holds the mode and control
// registers and the overflow flags, gates each channel's steps, and
// drives the read mux. Assumes gate_pin is already synchronous to clk.
// ev_pin may be asynchronous.
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int DIV = 12,
    parameter int W   = 8,
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic [NCH-1:0]    ev_pin,
    input  logic [NCH-1:0]    gate_pin,
    input  logic [NCH-1:0]    irq_ack,
    output logic [NCH-1:0]    irq
);
    localparam int NIB = 4;

    logic [W-1:0]   mode_q;
    logic [NCH-1:0] run_q, flag_q, flag_set, fall, go, step, aux_step;
    logic [NCH-1:0] ovf_main, ovf_aux, wr_lo, wr_hi;
    logic [W-1:0]   lo [NCH];
    logic [W-1:0]   hi [NCH];
    chan_cfg_t      cfg [NCH];
    logic           tick, wr_mode, wr_ctrl;

    assign wr_mode = wr_en && (wr_addr == A_MODE);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

    mc_prescaler #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign cfg[i]      = chan_cfg_t'(mode_q[NIB*i +: NIB]);
            assign go[i]       = run_q[i] && (!cfg[i].gate || gate_pin[i]);
            assign step[i]     = go[i] && (cfg[i].ext_sel ? fall[i] : tick);
            assign aux_step[i] = (i == 0) ? (tick && run_q[NCH-1]) : 1'b0;
            assign wr_lo[i]    = wr_en && (wr_addr == ADDR_W'(A_LO0 + 2*i));
            assign wr_hi[i]    = wr_en && (wr_addr == ADDR_W'(A_HI0 + 2*i));

            ev_detect u_ev (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .pin(ev_pin[i]), .fall(fall[i])
            );

            tc_channel #(.W(W), .SPLIT_OK(i == 0)) u_ch (
                .clk(clk), .rst_n(rst_n), .mode(cfg[i].mode),
                .step(step[i]), .aux_step(aux_step[i]),
                .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(wr_data),
                .lo(lo[i]), .hi(hi[i]),
                .ovf_main(ovf_main[i]), .ovf_aux(ovf_aux[i])
            );
        end
    endgenerate

    // Split mode routes channel 0's high-byte wrap to the last flag.
    assign flag_set[0] = ovf_main[0];
    assign flag_set[1] = ovf_main[1] || ovf_aux[0] || ovf_aux[1];

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= wr_data;
    end

    // Run bits and overflow flags: hardware set, then ack, then software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_ctrl) run_q[i] <= wr_data[NIB + 2*i];
                if (flag_set[i])     flag_q[i] <= 1'b1;
                else if (irq_ack[i]) flag_q[i] <= 1'b0;
                else if (wr_ctrl)    flag_q[i] <= wr_data[NIB + 2*i + 1];
            end
        end
    end

    assign irq = flag_q;

    // Register read mux.
    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = mode_q;
            A_CTRL:  rd_data = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
            A_LO0:   rd_data = lo[0];
            A_HI0:   rd_data = hi[0];
            A_LO1:   rd_data = lo[1];
            A_HI1:   rd_data = hi[1];
            default: rd_data = '0;
        endcase
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chk
            // R10
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                flag_set[i] |=> irq[i]);
            // R10
            ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_ack[i] && !flag_set[i]) |=> !irq[i]);
            // R3
            gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg[i].gate && !gate_pin[i]) |-> !step[i]);
        end
    endgenerate
endmodule

// File: tb/dual_timer_tb.sv
// Directed bench for dual_timer: one task per scenario.
module dual_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [1:0] ev_pin, gate_pin, irq_ack, irq;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_pin(ev_pin), .gate_pin(gate_pin), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, {8'h00, v}, {8'h00, exp});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Poll until the byte at address a moves away from old.
    task automatic wait_change(input logic [2:0] a, input logic [7:0] old);
        logic [7:0] v;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            rd(a, v);
            if (v != old) break;
        end
    endtask

    task automatic stop_all();
        wr(3'd1, 8'h00);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 6; a++) expect_reg("R12 reg", 3'(a), 8'h00);
        chk("R12 irq", {14'b0, irq}, 16'h0000);
    endtask

    task automatic t_regmap();
        wr(3'd0, 8'hA5);
        expect_reg("R9 mode readback", 3'd0, 8'hA5);
        wr(3'd1, 8'hFF);
        expect_reg("R9 ctrl low nibble zero", 3'd1, 8'hF0);
        chk("R10 irq follows written flags", {14'b0, irq}, 16'h0003);
        stop_all();
        wr(3'd0, 8'h00);
    endtask

    task automatic t_timer16();
        wr(3'd0, 8'h10);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h40);
        wait_cyc(12*7);
        expect_reg("R1 seven machine cycles", 3'd4, 8'h07);
        stop_all();
        wr(3'd0, 8'h01);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd1, 8'h10);
        wait_cyc(12);
        chk("R5 no flag before wrap", {14'b0, irq}, 16'h0000);
        wait_cyc(24);
        expect_reg("R5 low after wrap", 3'd2, 8'h01);
        expect_reg("R5 high after wrap", 3'd3, 8'h00);
        chk("R5 flag on wrap", {14'b0, irq}, 16'h0001);
        @(negedge clk); irq_ack = 2'b01; @(negedge clk); irq_ack = 2'b00;
        chk("R10 ack clears", {14'b0, irq}, 16'h0000);
        stop_all();
    endtask

    task automatic t_mode13();
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd1, 8'h10);
        wait_cyc(12);
        expect_reg("R4 low step", 3'd2, 8'hFF);
        chk("R4 no flag yet", {14'b0, irq}, 16'h0000);
        wait_cyc(12);
        expect_reg("R4 low keeps bits 7:5", 3'd2, 8'hE0);
        expect_reg("R4 high carry", 3'd3, 8'h00);
        chk("R4 flag", {14'b0, irq}, 16'h0001);
        stop_all();
    endtask

    task automatic t_reload();
        wr(3'd0, 8'h02);
        wr(3'd2, 8'hFD); wr(3'd3, 8'h80);
        wr(3'd1, 8'h10);
        wait_cyc(12*5);
        expect_reg("R6 reloaded low", 3'd2, 8'h82);
        expect_reg("R6 high unchanged", 3'd3, 8'h80);
        chk("R6 flag", {14'b0, irq}, 16'h0001);
        stop_all();
    endtask

    task automatic t_split();
        wr(3'd0, 8'h33);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd4, 8'h55); wr(3'd5, 8'h66);
        wr(3'd1, 8'h50);
        wait_cyc(24);
        expect_reg("R7 ch0 low", 3'd2, 8'h00);
        expect_reg("R7 ch0 high", 3'd3, 8'h01);
        chk("R7 both flags", {14'b0, irq}, 16'h0003);
        expect_reg("R9 ctrl flags and runs", 3'd1, 8'hF0);
        expect_reg("R8 ch1 low frozen", 3'd4, 8'h55);
        expect_reg("R8 ch1 high frozen", 3'd5, 8'h66);
        stop_all();
    endtask

    task automatic t_gate();
        gate_pin = 2'b00;
        wr(3'd0, 8'h09);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h10);
        wait_cyc(12*10);
        expect_reg("R3 held while gate low", 3'd2, 8'h00);
        gate_pin = 2'b01;
        wait_cyc(12*10);
        expect_reg("R3 runs while gate high", 3'd2, 8'h0A);
        gate_pin = 2'b00;
        stop_all();
    endtask

    task automatic t_event();
        wr(3'd0, 8'h50);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h40);
        for (int p = 0; p < 3; p++) begin
            ev_pin[1] = 1'b1; wait_cyc(30);
            ev_pin[1] = 1'b0; wait_cyc(30);
        end
        wait_cyc(40);
        expect_reg("R2 three falling edges", 3'd4, 8'h03);
        stop_all();
    endtask

    task automatic t_set_wins();
        wr(3'd0, 8'h01);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd1, 8'h10);
        wait_change(3'd2, 8'hFE);
        wait_cyc(11);
        irq_ack = 2'b01;
        @(negedge clk);
        irq_ack = 2'b00;
        chk("R10 set beats ack", {14'b0, irq}, 16'h0001);
        stop_all();
    endtask

    task automatic t_wr_override();
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h20); wr(3'd3, 8'h00);
        wr(3'd1, 8'h10);
        wait_change(3'd2, 8'h20);
        wait_cyc(11);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h50;
        @(negedge clk);
        wr_en = 1'b0;
        expect_reg("R11 write replaces step", 3'd2, 8'h50);
        wait_cyc(12);
        expect_reg("R11 resumes from written", 3'd2, 8'h51);
        stop_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        ev_pin = '0; gate_pin = '0; irq_ack = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_timer16();
        t_mode13();
        t_reload();
        t_split();
        t_gate();
        t_event();
        t_set_wins();
        t_wr_override();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule